// File: doc/BRIEF.md
# Shared-Array AES Column Mixer

This block applies the AES column-mixing step, forward or inverse, to one 32-bit state column. The `inv_mode` input picks the direction. The inverse direction has no multiplier array of its own with the large coefficients. In inverse mode the column first passes through a light pre-stage. That stage multiplies by a sparse circulant matrix whose only coefficients are 05, 04 and 00. Its result then goes through the same forward array that encryption uses. In forward mode the pre-stage is bypassed.

The block is meant to sit inside a combined encrypt/decrypt round. It runs after byte substitution and row shifting, and before the round key is added. All arithmetic is in GF(2^8). The result is registered and updates on every clock edge, so one column can be processed per cycle.

Top module: `mixcol_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `col_out` is all zeros after that edge.
- R2: Byte position: row 0 of the column is bits [31:24], row 1 is [23:16], row 2 is [15:8] and row 3 is [7:0]. This holds on both `col_in` and `col_out`.
- R3: With `inv_mode`=0, output row r is 02·a[r] ^ 03·a[r+1] ^ a[r+2] ^ a[r+3], with row indices taken modulo 4.
- R4: With `inv_mode`=1, output row r is 0E·a[r] ^ 0B·a[r+1] ^ 0D·a[r+2] ^ 09·a[r+3], with row indices taken modulo 4.
- R5: Field multiplication reduces by x^8+x^4+x^3+x+1. Doubling a byte whose top bit is 1 shifts it left and XORs 0x1B into the result.
- R6: The output reflects the inputs sampled at the previous rising edge. A new column may be applied on every cycle.
- R7: Applying the inverse mode to a forward-mode result returns the original column.
- R8: In both modes, the XOR of the four output bytes equals the XOR of the four input bytes.
- R9: A column whose four bytes are all equal maps to itself in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_mode | input | 1 | 0 selects forward mixing, 1 selects inverse mixing |
| col_in | input | 32 | Input column, row 0 in the top byte |
| col_out | output | 32 | Registered mixed column |

## Verification
The bench builds the unit with its default parameters: 8-bit field elements, four rows, the 0x1B reduction constant and a registered output. With these values the published worked example columns can be used directly as vectors, and the one-cycle latency can be observed. A separate reference in the bench multiplies directly by 0E/0B/0D/09 rather than by the factored form. Random columns are passed forward and then inverse through the unit, which exercises reduction in every byte position.

// File: rtl/mixcol_pkg.sv
package mixcol_pkg;
  localparam int BYTE_W = 8;
  localparam int ROWS   = 4;
  localparam int COL_W  = BYTE_W * ROWS;

  typedef logic [BYTE_W-1:0] gbyte_t;

  // multiply by x modulo the field polynomial (low bits given in poly)
  function automatic gbyte_t gf_dbl(input gbyte_t v, input gbyte_t poly);
    gf_dbl = {v[BYTE_W-2:0], 1'b0} ^ (v[BYTE_W-1] ? poly : '0);
  endfunction
endpackage

// File: rtl/mixcol_premix.sv
module mixcol_premix
  import mixcol_pkg::*;
#(
  parameter gbyte_t POLY = 8'h1B
) (
  input  logic [COL_W-1:0] col_in,
  output logic [COL_W-1:0] col_out
);
  gbyte_t a [ROWS];
  gbyte_t y [ROWS];

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam int OPP = (r + 2) % ROWS;
      assign a[r] = col_in[COL_W-1-r*BYTE_W -: BYTE_W];
      gbyte_t q_self, q_opp;
      // 04*v = double twice; 05*v = 04*v ^ v
      assign q_self = gf_dbl(gf_dbl(a[r], POLY), POLY);
      assign q_opp  = gf_dbl(gf_dbl(a[OPP], POLY), POLY);
      assign y[r] = q_self ^ a[r] ^ q_opp;
      assign col_out[COL_W-1-r*BYTE_W -: BYTE_W] = y[r];
    end
  endgenerate

  // R8: each column of the sparse matrix sums to 01, so byte parity survives
  always_comb begin
    if (!$isunknown(col_in)) begin
      a_r8_pre_parity: assert ((y[0]^y[1]^y[2]^y[3]) == (a[0]^a[1]^a[2]^a[3]))
        else $error("premix byte XOR changed");
      // R9: when opposite rows match, 05*v ^ 04*v = v
      if (a[0] == a[2] && a[1] == a[3])
        a_r9_pre_pairs: assert (col_out == col_in)
          else $error("premix not identity on paired column");
    end
  end
endmodule

// File: rtl/mixcol_fwd_array.sv
module mixcol_fwd_array
  import mixcol_pkg::*;
#(
  parameter gbyte_t POLY = 8'h1B
) (
  input  logic [COL_W-1:0] col_in,
  output logic [COL_W-1:0] col_out
);
  gbyte_t a [ROWS];
  gbyte_t d [ROWS];
  gbyte_t y [ROWS];

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_unpack
      assign a[r] = col_in[COL_W-1-r*BYTE_W -: BYTE_W];
      assign d[r] = gf_dbl(a[r], POLY);
    end
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam int N1 = (r + 1) % ROWS;
      localparam int N2 = (r + 2) % ROWS;
      localparam int N3 = (r + 3) % ROWS;
      // 02*a[r] ^ (02*a[r+1] ^ a[r+1]) ^ a[r+2] ^ a[r+3]
      assign y[r] = d[r] ^ d[N1] ^ a[N1] ^ a[N2] ^ a[N3];
      assign col_out[COL_W-1-r*BYTE_W -: BYTE_W] = y[r];
    end
  endgenerate

  always_comb begin
    if (!$isunknown(col_in)) begin
      a_r8_fwd_parity: assert ((y[0]^y[1]^y[2]^y[3]) == (a[0]^a[1]^a[2]^a[3]))
        else $error("forward array byte XOR changed");
    end
  end
endmodule

// File: rtl/mixcol_unit.sv
module mixcol_unit
  import mixcol_pkg::*;
#(
  parameter gbyte_t POLY    = 8'h1B,
  parameter bit     OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inv_mode,
  input  logic [31:0]      col_in,
  output logic [31:0]      col_out
);
  logic [COL_W-1:0] pre_col;
  logic [COL_W-1:0] arr_in;
  logic [COL_W-1:0] mixed;

  mixcol_premix #(.POLY(POLY)) u_pre (
    .col_in (col_in),
    .col_out(pre_col)
  );

  // forward mode bypasses the sparse pre-stage
  assign arr_in = inv_mode ? pre_col : col_in;

  mixcol_fwd_array #(.POLY(POLY)) u_arr (
    .col_in (arr_in),
    .col_out(mixed)
  );

  function automatic gbyte_t fold(input logic [COL_W-1:0] c);
    fold = c[31:24] ^ c[23:16] ^ c[15:8] ^ c[7:0];
  endfunction

  generate
    if (OUT_REG) begin : g_reg
      logic [COL_W-1:0] out_q;
      always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= mixed;
      end
      assign col_out = out_q;

      a_r1_reset_clears: assert property (@(posedge clk) rst |=> col_out == '0)
        else $error("output not cleared by reset");
      a_r8_parity_kept: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> fold(col_out) == $past(fold(col_in)))
        else $error("byte XOR not preserved");
      a_r9_uniform_fixed: assert property (@(posedge clk) disable iff (rst)
        (col_in[31:24] == col_in[23:16] && col_in[23:16] == col_in[15:8] &&
         col_in[15:8] == col_in[7:0]) |=> col_out == $past(col_in))
        else $error("uniform column not fixed");
      a_r6_stable_in: assert property (@(posedge clk) disable iff (rst)
        ($stable(col_in) && $stable(inv_mode) && !$past(rst)) |=> $stable(col_out))
        else $error("output moved with steady inputs");
    end else begin : g_comb
      assign col_out = mixed;
    end
  endgenerate
endmodule

// File: tb/tb_mixcol_unit.sv
`timescale 1ns/1ps
module tb_mixcol_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inv_mode = 1'b0;
  logic [31:0] col_in = '0;
  logic [31:0] col_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  mixcol_unit dut (.clk(clk), .rst(rst), .inv_mode(inv_mode),
                   .col_in(col_in), .col_out(col_out));

  // {inv_mode, input column, expected column}; row 0 is the top byte (R2)
  localparam int NV = 11;
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 32'hdb135345, 32'h8e4da1bc},
    {1'b0, 32'hf20a225c, 32'h9fdc589d},
    {1'b0, 32'h01010101, 32'h01010101},
    {1'b0, 32'hd4d4d4d5, 32'hd5d5d7d6},
    {1'b0, 32'h2d26314c, 32'h4d7ebdf8},
    {1'b1, 32'h8e4da1bc, 32'hdb135345},
    {1'b1, 32'h9fdc589d, 32'hf20a225c},
    {1'b1, 32'hd5d5d7d6, 32'hd4d4d4d5},
    {1'b1, 32'h4d7ebdf8, 32'h2d26314c},
    {1'b1, 32'hc6c6c6c6, 32'hc6c6c6c6},
    {1'b0, 32'h00000000, 32'h00000000}
  };

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [31:0] ref_mix(input logic inv, input logic [31:0] c);
    logic [7:0] a [4];
    logic [7:0] k [4];
    logic [31:0] r;
    for (int i = 0; i < 4; i++) a[i] = c[31-8*i -: 8];
    if (inv) k = '{8'h0E, 8'h0B, 8'h0D, 8'h09};
    else     k = '{8'h02, 8'h03, 8'h01, 8'h01};
    for (int i = 0; i < 4; i++) begin
      logic [7:0] s = 8'h00;
      for (int j = 0; j < 4; j++) s ^= gmul(k[j], a[(i+j)%4]);
      r[31-8*i -: 8] = s;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // inputs change at negedge; the result is registered at the next posedge
  task automatic apply(input logic m, input logic [31:0] c);
    @(negedge clk);
    inv_mode = m;
    col_in   = c;
  endtask

  initial begin
    #40000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] prev_exp;
    logic [31:0] x, f;
    apply(1'b0, 32'hdb135345);
    @(negedge clk);
    check("R1 reset", col_out, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R3 first after reset", col_out, 32'h8e4da1bc);

    // vector table, one new column per cycle (R3 R4 R5 R2 R9)
    prev_exp = 32'h8e4da1bc;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][64], VEC[i][63:32]);
      #1 check("R6 holds until edge", col_out, prev_exp);
      @(negedge clk);
      check(VEC[i][64] ? "R4 inverse vector" : "R3 forward vector", col_out, VEC[i][31:0]);
      check("R5 reference model", col_out, ref_mix(VEC[i][64], VEC[i][63:32]));
      prev_exp = VEC[i][31:0];
    end

    // R2: single nonzero byte in row 1 spreads per circulant rows
    apply(1'b0, 32'h00800000);
    @(negedge clk);
    check("R2 row placement", col_out, 32'h9b1b8080);

    // R9: uniform column in both modes
    apply(1'b1, 32'h77777777);
    @(negedge clk);
    check("R9 uniform inverse", col_out, 32'h77777777);

    // R7 and R8: random roundtrip
    for (int n = 0; n < 40; n++) begin
      x = $urandom;
      apply(1'b0, x);
      @(negedge clk);
      f = col_out;
      check("R3 random forward", f, ref_mix(1'b0, x));
      check("R8 byte xor", {24'h0, f[31:24]^f[23:16]^f[15:8]^f[7:0]},
            {24'h0, x[31:24]^x[23:16]^x[15:8]^x[7:0]});
      inv_mode = 1'b1;
      col_in   = f;
      @(negedge clk);
      check("R7 roundtrip", col_out, x);
    end

    // R1: reset in mid-stream
    apply(1'b1, 32'h12345678);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", col_out, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R4 after reset release", col_out, ref_mix(1'b1, 32'h12345678));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule